// File: doc/BRIEF.md
# Recurrence-Driven Oscillator Bin Parameter Generator

This block feeds a bank of sinusoidal oscillators with a frequency word, a phase word and an amplitude for every bin. It does not read these values from a per-bin memory. It computes them bin by bin from a handful of seed constants. After a frame-start strobe it issues one bin per clock, bin 0 through bin N−1, and then goes quiet until the next strobe. The sine evaluation and the summing of bins happen downstream and are not part of this block.

Frequency and phase each come from a second-order difference scheme. A running value is increased by a first difference, and that first difference is itself increased by a constant second difference after every bin. The result is a quadratic spread of bin frequencies or phases, built from adders only. The amplitude is multiplied by a ratio after every bin, and the ratio is in turn multiplied by a constant factor. This gives a geometric taper whose slope bends from one end of the frame to the other. All constants are written through a small configuration port. The block copies them into its working registers only when a frame starts.

Top module: `bin_param_gen`

## Requirements
- R1: While reset is asserted and right after it, out_valid is 0 and out_bin, out_freq, out_phase and out_amp are all zero.
- R2: The clock edge that samples frame_start high loads all working registers. After that edge out_valid is 1 (if N is non-zero), out_bin is 0, out_freq equals the frequency base, out_phase equals the phase base and out_amp equals the amplitude base.
- R3: Within a frame out_bin rises by one every clock, and out_valid stays high for exactly N clocks (bins 0..N−1). It then stays low until the next strobe. While out_valid is low the output words hold their last values.
- R4: Frequency follows F(k+1) = F(k) + D(k) and D(k+1) = D(k) + S, where D(0) is the first-difference seed and S the second difference. All are 32-bit and wrap modulo 2^32.
- R5: Phase follows the same second-order scheme with its own base, first-difference seed and second difference, also 32-bit modulo 2^32.
- R6: Amplitude follows A(k+1) = min(floor(A(k)·Q(k)/2^30), 2^24−1) and Q(k+1) = min(floor(Q(k)·M/2^30), 2^32−1). Q and M are unsigned Q2.30 (0x40000000 is 1.0), and A is 24-bit unsigned.
- R7: A strobe that arrives in the middle of a frame restarts the frame at bin 0 with the base values.
- R8: Configuration writes use cfg_sel codes 0 frequency base, 1 frequency first difference, 2 frequency second difference, 3 phase base, 4 phase first difference, 5 phase second difference, 6 amplitude base (low 24 bits), 7 ratio seed, 8 ratio multiplier, 9 bin count. Codes 10 to 15 change nothing. A write has no effect on a frame in progress and takes effect at the next strobe.
- R9: A bin count of zero makes a strobe produce no valid bin.
- R10: A bin count written above 2048 is treated as 2048, so the last bin index is 2047.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write enable |
| cfg_sel | input | 4 | Configuration register select code |
| cfg_data | input | 32 | Configuration write data |
| frame_start | input | 1 | Starts (or restarts) a frame at bin 0 |
| out_valid | output | 1 | High while a bin is presented |
| out_bin | output | 11 | Index of the presented bin |
| out_freq | output | 32 | Frequency word of the bin |
| out_phase | output | 32 | Phase word of the bin |
| out_amp | output | 24 | Amplitude of the bin |

## Verification
The bench targets several corner cases. One is frequency and phase that wrap through 2^32 with negative second differences: a design that saturated or sign-extended would drift off the quadratic sequence. Another is an amplitude product and a ratio product large enough to overflow. A design that wrapped there would produce a small amplitude where full scale belongs. The bench also restarts a frame in its middle, writes configuration while a frame runs, sets a zero bin count and sets one above 2048. Wrong handling of these would show up as a late reset of the index, a corrupted frame, a single stray valid bin, or a frame that runs past bin 2047.

// File: rtl/bpg_pkg.sv
package bpg_pkg;
    typedef enum logic [3:0] {
        SEL_F_BASE = 4'd0,
        SEL_F_D1   = 4'd1,
        SEL_F_D2   = 4'd2,
        SEL_P_BASE = 4'd3,
        SEL_P_D1   = 4'd4,
        SEL_P_D2   = 4'd5,
        SEL_A_BASE = 4'd6,
        SEL_R_BASE = 4'd7,
        SEL_R_MULT = 4'd8,
        SEL_COUNT  = 4'd9
    } cfg_sel_e;

    // number of additive second-order channels (frequency, phase)
    localparam int NUM_ACC = 2;
endpackage

// File: rtl/bpg_cfg_bank.sv
module bpg_cfg_bank
    import bpg_pkg::*;
#(
    parameter int WORD_W  = 32,
    parameter int AMP_W   = 24,
    parameter int CNT_W   = 12,
    parameter int BIN_MAX = 2048
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [3:0]        sel,
    input  logic [WORD_W-1:0] data,
    output logic [WORD_W-1:0] f_base,
    output logic [WORD_W-1:0] f_d1,
    output logic [WORD_W-1:0] f_d2,
    output logic [WORD_W-1:0] p_base,
    output logic [WORD_W-1:0] p_d1,
    output logic [WORD_W-1:0] p_d2,
    output logic [AMP_W-1:0]  a_base,
    output logic [WORD_W-1:0] r_base,
    output logic [WORD_W-1:0] r_mult,
    output logic [CNT_W-1:0]  count
);
    typedef struct packed {
        logic [WORD_W-1:0] f_base;
        logic [WORD_W-1:0] f_d1;
        logic [WORD_W-1:0] f_d2;
        logic [WORD_W-1:0] p_base;
        logic [WORD_W-1:0] p_d1;
        logic [WORD_W-1:0] p_d2;
        logic [AMP_W-1:0]  a_base;
        logic [WORD_W-1:0] r_base;
        logic [WORD_W-1:0] r_mult;
        logic [CNT_W-1:0]  count;
    } bank_t;

    bank_t bank_d, bank_q;

    always_comb begin
        bank_d = bank_q;
        if (we) begin
            case (cfg_sel_e'(sel))
                SEL_F_BASE: bank_d.f_base = data;
                SEL_F_D1:   bank_d.f_d1   = data;
                SEL_F_D2:   bank_d.f_d2   = data;
                SEL_P_BASE: bank_d.p_base = data;
                SEL_P_D1:   bank_d.p_d1   = data;
                SEL_P_D2:   bank_d.p_d2   = data;
                SEL_A_BASE: bank_d.a_base = data[AMP_W-1:0];
                SEL_R_BASE: bank_d.r_base = data;
                SEL_R_MULT: bank_d.r_mult = data;
                SEL_COUNT: begin
                    if (data > WORD_W'(BIN_MAX)) bank_d.count = CNT_W'(BIN_MAX);
                    else                         bank_d.count = data[CNT_W-1:0];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bank_q <= '0;
        else        bank_q <= bank_d;
    end

    assign f_base = bank_q.f_base;
    assign f_d1   = bank_q.f_d1;
    assign f_d2   = bank_q.f_d2;
    assign p_base = bank_q.p_base;
    assign p_d1   = bank_q.p_d1;
    assign p_d2   = bank_q.p_d2;
    assign a_base = bank_q.a_base;
    assign r_base = bank_q.r_base;
    assign r_mult = bank_q.r_mult;
    assign count  = bank_q.count;
endmodule

// File: rtl/bpg_frame_seq.sv
module bpg_frame_seq #(
    parameter int BIN_W = 11,
    parameter int CNT_W = BIN_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_start,
    input  logic [CNT_W-1:0] count_in,
    output logic             load,
    output logic             step,
    output logic             valid,
    output logic [BIN_W-1:0] bin
);
    typedef struct packed {
        logic             valid;
        logic [BIN_W-1:0] bin;
        logic [CNT_W-1:0] count;
    } seq_t;

    seq_t s_d, s_q;
    logic [CNT_W-1:0] next_idx;
    logic             last;

    always_comb begin
        next_idx = {1'b0, s_q.bin} + CNT_W'(1);
        last     = (next_idx == s_q.count);
        s_d      = s_q;
        load     = 1'b0;
        step     = 1'b0;
        if (frame_start) begin
            s_d.valid = (count_in != '0);
            s_d.bin   = '0;
            s_d.count = count_in;
            load      = 1'b1;
        end else if (s_q.valid) begin
            if (last) begin
                s_d.valid = 1'b0;
            end else begin
                s_d.bin = next_idx[BIN_W-1:0];
                step    = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign valid = s_q.valid;
    assign bin   = s_q.bin;
endmodule

// File: rtl/bpg_diff2.sv
module bpg_diff2 #(
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              step,
    input  logic [WORD_W-1:0] seed_val,
    input  logic [WORD_W-1:0] seed_d1,
    input  logic [WORD_W-1:0] seed_d2,
    output logic [WORD_W-1:0] val
);
    typedef struct packed {
        logic [WORD_W-1:0] val;
        logic [WORD_W-1:0] d1;
        logic [WORD_W-1:0] d2;
    } acc_t;

    acc_t a_d, a_q;

    always_comb begin
        a_d = a_q;
        if (load) begin
            a_d.val = seed_val;
            a_d.d1  = seed_d1;
            a_d.d2  = seed_d2;
        end else if (step) begin
            a_d.val = a_q.val + a_q.d1;
            a_d.d1  = a_q.d1 + a_q.d2;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) a_q <= '0;
        else        a_q <= a_d;
    end

    assign val = a_q.val;
endmodule

// File: rtl/bpg_geo_amp.sv
module bpg_geo_amp #(
    parameter int AMP_W  = 24,
    parameter int Q_W    = 32,
    parameter int FRAC_W = 30
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             step,
    input  logic [AMP_W-1:0] seed_amp,
    input  logic [Q_W-1:0]   seed_ratio,
    input  logic [Q_W-1:0]   seed_mult,
    output logic [AMP_W-1:0] amp
);
    localparam int PA_W = AMP_W + Q_W;
    localparam int PR_W = 2 * Q_W;

    typedef struct packed {
        logic [AMP_W-1:0] amp;
        logic [Q_W-1:0]   ratio;
        logic [Q_W-1:0]   mult;
    } geo_t;

    geo_t g_d, g_q;
    logic [PA_W-1:0] amp_prod, amp_shift;
    logic [PR_W-1:0] rat_prod, rat_shift;

    always_comb begin
        amp_prod  = PA_W'(g_q.amp) * PA_W'(g_q.ratio);
        amp_shift = amp_prod >> FRAC_W;
        rat_prod  = PR_W'(g_q.ratio) * PR_W'(g_q.mult);
        rat_shift = rat_prod >> FRAC_W;
        g_d = g_q;
        if (load) begin
            g_d.amp   = seed_amp;
            g_d.ratio = seed_ratio;
            g_d.mult  = seed_mult;
        end else if (step) begin
            if (|amp_shift[PA_W-1:AMP_W]) g_d.amp = '1;
            else                          g_d.amp = amp_shift[AMP_W-1:0];
            if (|rat_shift[PR_W-1:Q_W])   g_d.ratio = '1;
            else                          g_d.ratio = rat_shift[Q_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) g_q <= '0;
        else        g_q <= g_d;
    end

    assign amp = g_q.amp;
endmodule

// File: rtl/bin_param_gen.sv
module bin_param_gen
    import bpg_pkg::*;
#(
    parameter int BIN_W  = 11,
    parameter int WORD_W = 32,
    parameter int AMP_W  = 24,
    parameter int FRAC_W = 30
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [3:0]        cfg_sel,
    input  logic [WORD_W-1:0] cfg_data,
    input  logic              frame_start,
    output logic              out_valid,
    output logic [BIN_W-1:0]  out_bin,
    output logic [WORD_W-1:0] out_freq,
    output logic [WORD_W-1:0] out_phase,
    output logic [AMP_W-1:0]  out_amp
);
    localparam int CNT_W   = BIN_W + 1;
    localparam int BIN_MAX = 1 << BIN_W;

    logic [WORD_W-1:0] f_base, f_d1, f_d2, p_base, p_d1, p_d2, r_base, r_mult;
    logic [AMP_W-1:0]  a_base;
    logic [CNT_W-1:0]  count;
    logic              load, step;

    logic [WORD_W-1:0] seed_v [NUM_ACC];
    logic [WORD_W-1:0] seed_d1 [NUM_ACC];
    logic [WORD_W-1:0] seed_d2 [NUM_ACC];
    logic [WORD_W-1:0] acc_v [NUM_ACC];

    bpg_cfg_bank #(
        .WORD_W(WORD_W), .AMP_W(AMP_W), .CNT_W(CNT_W), .BIN_MAX(BIN_MAX)
    ) u_cfg (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .sel(cfg_sel), .data(cfg_data),
        .f_base(f_base), .f_d1(f_d1), .f_d2(f_d2),
        .p_base(p_base), .p_d1(p_d1), .p_d2(p_d2),
        .a_base(a_base), .r_base(r_base), .r_mult(r_mult), .count(count)
    );

    bpg_frame_seq #(.BIN_W(BIN_W), .CNT_W(CNT_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .count_in(count),
        .load(load), .step(step), .valid(out_valid), .bin(out_bin)
    );

    assign seed_v[0]  = f_base;
    assign seed_d1[0] = f_d1;
    assign seed_d2[0] = f_d2;
    assign seed_v[1]  = p_base;
    assign seed_d1[1] = p_d1;
    assign seed_d2[1] = p_d2;

    for (genvar g = 0; g < NUM_ACC; g++) begin : g_acc
        bpg_diff2 #(.WORD_W(WORD_W)) u_acc (
            .clk(clk), .rst_n(rst_n), .load(load), .step(step),
            .seed_val(seed_v[g]), .seed_d1(seed_d1[g]), .seed_d2(seed_d2[g]),
            .val(acc_v[g])
        );
    end

    assign out_freq  = acc_v[0];
    assign out_phase = acc_v[1];

    bpg_geo_amp #(.AMP_W(AMP_W), .Q_W(WORD_W), .FRAC_W(FRAC_W)) u_amp (
        .clk(clk), .rst_n(rst_n), .load(load), .step(step),
        .seed_amp(a_base), .seed_ratio(r_base), .seed_mult(r_mult),
        .amp(out_amp)
    );
endmodule

// File: rtl/bpg_checker.sv
module bpg_checker #(
    parameter int BIN_W  = 11,
    parameter int WORD_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              frame_start,
    input logic              out_valid,
    input logic [BIN_W-1:0]  out_bin,
    input logic [WORD_W-1:0] out_freq
);
    assert_start_bin0_R2: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> (out_bin == '0));

    assert_bin_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !frame_start) |=> (!out_valid || out_bin == $past(out_bin) + BIN_W'(1)));

    assert_idle_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!out_valid && !frame_start) |=> !out_valid);

    assert_idle_freq_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!out_valid && !frame_start) |=> $stable(out_freq));

    assert_valid_needs_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> $past(frame_start));
endmodule

bind bin_param_gen bpg_checker #(.BIN_W(BIN_W), .WORD_W(WORD_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
    .out_valid(out_valid), .out_bin(out_bin), .out_freq(out_freq)
);

// File: tb/sim_bin_param_gen.sv
module sim_bin_param_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_sel = '0;
    logic [31:0] cfg_data = '0;
    logic        frame_start = 1'b0;
    logic        out_valid;
    logic [10:0] out_bin;
    logic [31:0] out_freq, out_phase;
    logic [23:0] out_amp;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    bin_param_gen u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_data(cfg_data), .frame_start(frame_start), .out_valid(out_valid),
        .out_bin(out_bin), .out_freq(out_freq), .out_phase(out_phase), .out_amp(out_amp)
    );

    // per vector: fbase fd1 fd2 pbase pd1 pd2 abase rseed rmult count
    localparam logic [31:0] VEC [4][10] = '{
        '{32'd100, 32'd10, 32'd2, 32'd0, 32'd5, 32'd0,
          32'd1000, 32'h4000_0000, 32'h4000_0000, 32'd8},
        '{32'hFFFF_FFF0, 32'd7, 32'hFFFF_FFFF, 32'h8000_0000, 32'd3, 32'h4000_0000,
          32'h0080_0000, 32'h4800_0000, 32'h3E00_0000, 32'd20},
        '{32'd0, 32'd0, 32'd1000, 32'd1, 32'd1, 32'd1,
          32'h00F0_0000, 32'h6000_0000, 32'h4000_0000, 32'd6},
        '{32'd5, 32'hFFFF_0000, 32'd256, 32'd0, 32'd0, 32'hFFFF_FFFF,
          32'd256, 32'hF000_0000, 32'h8000_0000, 32'd5}
    };

    logic [31:0] shadow [10];
    longint unsigned mf, mfd, mfd2, mp, mpd, mpd2, ma, mr, mm;
    int mn;

    task automatic chk(input string tag, input longint unsigned act, input longint unsigned exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cfg_write(input int sel, input logic [31:0] data);
        cfg_we = 1'b1;
        cfg_sel = sel[3:0];
        cfg_data = data;
        if (sel < 10) shadow[sel] = data;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic load_vec(input int i);
        for (int s = 0; s < 10; s++) cfg_write(s, VEC[i][s]);
    endtask

    task automatic model_load();
        mf = shadow[0]; mfd = shadow[1]; mfd2 = shadow[2];
        mp = shadow[3]; mpd = shadow[4]; mpd2 = shadow[5];
        ma = shadow[6] & 32'h00FF_FFFF; mr = shadow[7]; mm = shadow[8];
        mn = (shadow[9] > 2048) ? 2048 : int'(shadow[9]);
    endtask

    task automatic model_step();
        longint unsigned t;
        mf = (mf + mfd) & 64'hFFFF_FFFF;
        mfd = (mfd + mfd2) & 64'hFFFF_FFFF;
        mp = (mp + mpd) & 64'hFFFF_FFFF;
        mpd = (mpd + mpd2) & 64'hFFFF_FFFF;
        t = (ma * mr) >> 30;
        ma = (t > 64'hFF_FFFF) ? 64'hFF_FFFF : t;
        t = (mr * mm) >> 30;
        mr = (t > 64'hFFFF_FFFF) ? 64'hFFFF_FFFF : t;
    endtask

    task automatic check_bin(input int k);
        chk("R3 valid", out_valid, 1);
        chk("R3 bin", out_bin, k);
        chk("R4 freq", out_freq, mf);
        chk("R5 phase", out_phase, mp);
        chk("R6 amp", out_amp, ma);
    endtask

    task automatic strobe();
        frame_start = 1'b1;
        @(negedge clk);
        frame_start = 1'b0;
        model_load();
    endtask

    // limit < 0: whole frame plus the trailing idle check
    task automatic run_frame(input int limit);
        int n;
        strobe();
        n = (limit < 0 || limit > mn) ? mn : limit;
        for (int k = 0; k < n; k++) begin
            if (k == 0) chk("R2 first bin", out_bin, 0);
            check_bin(k);
            model_step();
            @(negedge clk);
        end
        if (limit < 0) begin
            chk("R3 valid low after frame", out_valid, 0);
            @(negedge clk);
            chk("R3 valid stays low", out_valid, 0);
        end
    endtask

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        for (int s = 0; s < 10; s++) shadow[s] = '0;
        repeat (3) @(negedge clk);
        chk("R1 valid in reset", out_valid, 0);
        chk("R1 freq in reset", out_freq, 0);
        chk("R1 amp in reset", out_amp, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 valid after reset", out_valid, 0);
        chk("R1 bin after reset", out_bin, 0);
        chk("R1 phase after reset", out_phase, 0);

        // table of vectors: R4 R5 R6 wrap and saturation cases
        for (int i = 0; i < 4; i++) begin
            load_vec(i);
            run_frame(-1);
        end

        // R7: restart in the middle of a frame
        load_vec(1);
        run_frame(5);
        run_frame(-1);

        // R8: writes during a frame, and unused codes, do not disturb it
        load_vec(0);
        cfg_write(12, 32'hDEAD_BEEF);
        strobe();
        for (int k = 0; k < mn; k++) begin
            check_bin(k);
            model_step();
            if (k == 2) begin
                cfg_we = 1'b1; cfg_sel = 4'd0; cfg_data = 32'h1234_5678;
                shadow[0] = 32'h1234_5678;
            end else begin
                cfg_we = 1'b0;
            end
            @(negedge clk);
        end
        cfg_we = 1'b0;
        chk("R8 frame length kept", out_valid, 0);
        strobe();
        chk("R8 new base used", out_freq, 32'h1234_5678);
        repeat (10) @(negedge clk);

        // R9: zero count yields nothing
        cfg_write(9, 32'd0);
        strobe();
        chk("R9 no valid", out_valid, 0);
        @(negedge clk);
        chk("R9 still no valid", out_valid, 0);

        // R10: oversized count clamps to 2048
        load_vec(0);
        cfg_write(9, 32'd3000);
        strobe();
        chk("R10 count clamp", mn, 2048);
        for (int k = 0; k < 2048; k++) begin
            check_bin(k);
            model_step();
            @(negedge clk);
        end
        chk("R10 stops after 2047", out_valid, 0);
        chk("R10 last index held", out_bin, 2047);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule